// File: doc/BRIEF.md
# Ethernet Frame Header Extractor

This block takes received Ethernet frames on a 64-bit byte-enabled stream and splits each frame into two streams. The first fourteen bytes form a parallel header record: destination address, source address and type. That record is offered on its own valid/ready port. All bytes after the header leave on a 64-bit payload stream, shifted so that the first payload byte lands in the lowest byte lane.

The header ends six bytes into the second input beat. Each output beat therefore joins the top two lanes of one input beat with the low six lanes of the next. When the last input beat holds more than six bytes, one trailing beat is added. A frame of fourteen bytes or fewer is counted as truncated. It raises a one-cycle error pulse and produces no output at all. The input, the header port and the payload port can each stall at any time.

Top module: `frame_hdr_split`

## Requirements
- R1: Byte lane i of a beat is bits [8i+7:8i]. Frame byte 0 arrives in lane 0 of the first beat. Frame bytes 0..5 form `hdr_dst`, bytes 6..11 form `hdr_src` and bytes 12..13 form `hdr_type`. In each field the byte received first is the most significant byte. One header record is emitted for each frame longer than 14 bytes.
- R2: Payload byte j (frame byte 14+j) appears in lane j mod 8 of payload beat j div 8. Kept lanes are contiguous from lane 0, and every payload beat other than the last has all eight keep bits set.
- R3: A payload of P bytes leaves in exactly ceil(P/8) beats. The last of these beats has `p_last` set and (P-1) mod 8 + 1 keep bits set. When the last input beat carries more than six bytes, one extra beat follows that input beat.
- R4: `p_user` on the last payload beat equals `s_user` on the last input beat of the same frame. `p_user` is low on every other payload beat.
- R5: A frame that ends after 1 to 14 bytes raises `hdr_trunc_err` for exactly one cycle. No header record and no payload beat are produced for that frame.
- R6: A frame that directly follows a truncated frame is parsed correctly.
- R7: Frames sent back to back, with payloads of 1 to 17 bytes, are all delivered without loss under any mix of input gaps and output stalls. A payload beat that is not accepted holds its data, keep, last and user.
- R8: A header record stays valid and unchanged until it is accepted. The next frame's header is not presented before that, and frames keep their order.
- R9: `busy` is high while a frame is part-way through the block and low when the block is idle.
- R10: After reset, `s_ready` is high and `p_valid`, `hdr_valid`, `busy` and `hdr_trunc_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_data | input | 64 | Input frame data, lane 0 first |
| s_keep | input | 8 | Input byte enables |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted |
| s_last | input | 1 | Last beat of the frame |
| s_user | input | 1 | Frame flag, used on the last beat |
| hdr_valid | output | 1 | Header record valid |
| hdr_ready | input | 1 | Header record accepted |
| hdr_dst | output | 48 | Destination address |
| hdr_src | output | 48 | Source address |
| hdr_type | output | 16 | Type field |
| p_data | output | 64 | Payload data, realigned |
| p_keep | output | 8 | Payload byte enables |
| p_valid | output | 1 | Payload beat valid |
| p_ready | input | 1 | Payload beat accepted |
| p_last | output | 1 | Last payload beat |
| p_user | output | 1 | Frame flag on the last payload beat |
| busy | output | 1 | Frame in progress |
| hdr_trunc_err | output | 1 | Pulse: frame ended inside the header |

## Verification
The assertions rely on three properties of the input. Input keep is contiguous from lane 0. Every input beat except the last is full. The source holds a beat steady until it is accepted. With those inputs, the payload keep properties and the hold properties hold at the output ports. The stimulus cuts every input beat from a byte array, so keep always follows the byte count and is full except on the last beat. The source changes its signals only after a handshake. Gaps, payload stalls and header stalls are switched on by a mode word that the sweep steps through.

// File: rtl/frame_hdr_pkg.sv
`timescale 1ns/1ps
package frame_hdr_pkg;
  localparam int FHS_DATA_W     = 64;
  localparam int FHS_MAC_BYTES  = 6;
  localparam int FHS_TYPE_BYTES = 2;

  typedef enum logic [1:0] {
    ST_HEAD0 = 2'd0,
    ST_HEAD1 = 2'd1,
    ST_BODY  = 2'd2,
    ST_TAIL  = 2'd3
  } fhs_state_e;
endpackage

// File: rtl/fhs_ctrl.sv
`timescale 1ns/1ps
module fhs_ctrl
  import frame_hdr_pkg::*;
#(
  parameter int KEEP_W    = 8,
  parameter int HEAD_TAIL = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic              s_last,
  input  logic              s_user,
  input  logic [KEEP_W-1:0] s_keep,
  output logic              s_ready,
  input  logic              hdr_free,
  input  logic              pl_free,
  output logic              beat0_cap,
  output logic              hdr_cap,
  output logic              body_cap,
  output logic              tail_emit,
  output logic [KEEP_W-1:0] o_keep,
  output logic              o_last,
  output logic              o_user,
  output logic              trunc_err,
  output logic              in_frame
);
  localparam int CNT_W       = $clog2(KEEP_W + 1);
  localparam int CARRY_LANES = KEEP_W - HEAD_TAIL;

  function automatic logic [KEEP_W-1:0] lane_mask(input int n);
    logic [KEEP_W-1:0] m;
    for (int i = 0; i < KEEP_W; i++) m[i] = (i < n);
    return m;
  endfunction

  fhs_state_e        st_q, st_d;
  logic [CNT_W-1:0]  nbytes;
  logic [CNT_W-1:0]  tail_n_q;
  logic              tail_user_q;
  logic              fire, short_end, trunc_now, to_tail;

  always_comb begin
    nbytes = '0;
    for (int i = 0; i < KEEP_W; i++) nbytes = nbytes + CNT_W'(s_keep[i]);
  end

  assign short_end = (nbytes <= CNT_W'(HEAD_TAIL));

  always_comb begin
    case (st_q)
      ST_HEAD0: s_ready = 1'b1;
      ST_HEAD1: s_ready = hdr_free;
      ST_BODY:  s_ready = pl_free;
      default:  s_ready = 1'b0;
    endcase
  end

  assign fire      = s_valid & s_ready;
  assign beat0_cap = fire & (st_q == ST_HEAD0) & ~s_last;
  assign hdr_cap   = fire & (st_q == ST_HEAD1) & ~(s_last & short_end);
  assign body_cap  = fire & (st_q == ST_BODY);
  assign tail_emit = (st_q == ST_TAIL) & pl_free;
  assign trunc_now = fire & s_last &
                     ((st_q == ST_HEAD0) | ((st_q == ST_HEAD1) & short_end));
  assign to_tail   = (hdr_cap | body_cap) & s_last & ~short_end;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_HEAD0: if (fire && !s_last) st_d = ST_HEAD1;
      ST_HEAD1: if (fire) st_d = !s_last ? ST_BODY : (short_end ? ST_HEAD0 : ST_TAIL);
      ST_BODY:  if (fire && s_last) st_d = short_end ? ST_HEAD0 : ST_TAIL;
      default:  if (pl_free) st_d = ST_HEAD0;
    endcase
  end

  always_comb begin
    if (st_q == ST_TAIL) begin
      o_keep = lane_mask(int'(tail_n_q));
      o_last = 1'b1;
      o_user = tail_user_q;
    end else if (s_last && short_end) begin
      o_keep = lane_mask(CARRY_LANES + int'(nbytes));
      o_last = 1'b1;
      o_user = s_user;
    end else begin
      o_keep = '1;
      o_last = 1'b0;
      o_user = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_HEAD0;
      trunc_err   <= 1'b0;
      tail_n_q    <= '0;
      tail_user_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      trunc_err <= trunc_now;
      if (to_tail) begin
        tail_n_q    <= nbytes - CNT_W'(HEAD_TAIL);
        tail_user_q <= s_user;
      end
    end
  end

  assign in_frame = (st_q != ST_HEAD0);
endmodule

// File: rtl/fhs_hdr_reg.sv
`timescale 1ns/1ps
module fhs_hdr_reg #(
  parameter int DATA_W     = 64,
  parameter int MAC_BYTES  = 6,
  parameter int TYPE_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [DATA_W-1:0]      s_data,
  input  logic                   beat0_cap,
  input  logic                   hdr_cap,
  input  logic                   hdr_ready,
  output logic                   hdr_valid,
  output logic                   hdr_free,
  output logic [8*MAC_BYTES-1:0] hdr_dst,
  output logic [8*MAC_BYTES-1:0] hdr_src,
  output logic [8*TYPE_BYTES-1:0] hdr_type
);
  localparam int HDR_BYTES = 2 * MAC_BYTES + TYPE_BYTES;
  localparam int HEAD_TAIL = HDR_BYTES - DATA_W / 8;

  logic [DATA_W-1:0]        stage_q;
  logic [8*HDR_BYTES-1:0]   word;
  logic [8*MAC_BYTES-1:0]   dst_d, src_d;
  logic [8*TYPE_BYTES-1:0]  type_d;

  assign word = {s_data[8*HEAD_TAIL-1:0], stage_q};

  always_comb begin
    for (int i = 0; i < MAC_BYTES; i++) begin
      dst_d[8*(MAC_BYTES-1-i) +: 8] = word[8*i +: 8];
      src_d[8*(MAC_BYTES-1-i) +: 8] = word[8*(MAC_BYTES+i) +: 8];
    end
    for (int i = 0; i < TYPE_BYTES; i++)
      type_d[8*(TYPE_BYTES-1-i) +: 8] = word[8*(2*MAC_BYTES+i) +: 8];
  end

  always_ff @(posedge clk) begin
    if (beat0_cap) stage_q <= s_data;
    if (hdr_cap) begin
      hdr_dst  <= dst_d;
      hdr_src  <= src_d;
      hdr_type <= type_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            hdr_valid <= 1'b0;
    else if (hdr_cap)   hdr_valid <= 1'b1;
    else if (hdr_ready) hdr_valid <= 1'b0;
  end

  assign hdr_free = ~hdr_valid | hdr_ready;
endmodule

// File: rtl/fhs_realign.sv
`timescale 1ns/1ps
module fhs_realign #(
  parameter int DATA_W      = 64,
  parameter int CARRY_LANES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   s_data,
  input  logic                hdr_cap,
  input  logic                body_cap,
  input  logic                tail_emit,
  input  logic [DATA_W/8-1:0] o_keep,
  input  logic                o_last,
  input  logic                o_user,
  input  logic                p_ready,
  output logic                p_valid,
  output logic [DATA_W-1:0]   p_data,
  output logic [DATA_W/8-1:0] p_keep,
  output logic                p_last,
  output logic                p_user,
  output logic                pl_free
);
  localparam int CARRY_W = 8 * CARRY_LANES;
  localparam int LOW_W   = DATA_W - CARRY_W;

  logic [CARRY_W-1:0] carry_q;
  logic               load;

  assign load = body_cap | tail_emit;

  always_ff @(posedge clk) begin
    if (hdr_cap | body_cap) carry_q <= s_data[DATA_W-1 -: CARRY_W];
    if (load) begin
      p_data <= tail_emit ? {{LOW_W{1'b0}}, carry_q} : {s_data[LOW_W-1:0], carry_q};
      p_keep <= o_keep;
      p_last <= o_last;
      p_user <= o_user;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          p_valid <= 1'b0;
    else if (load)    p_valid <= 1'b1;
    else if (p_ready) p_valid <= 1'b0;
  end

  assign pl_free = ~p_valid | p_ready;
endmodule

// File: rtl/frame_hdr_split.sv
`timescale 1ns/1ps
module frame_hdr_split
  import frame_hdr_pkg::*;
#(
  parameter  int DATA_W      = FHS_DATA_W,
  parameter  int MAC_BYTES   = FHS_MAC_BYTES,
  parameter  int TYPE_BYTES  = FHS_TYPE_BYTES,
  localparam int KEEP_W      = DATA_W / 8,
  localparam int HDR_BYTES   = 2 * MAC_BYTES + TYPE_BYTES,
  localparam int HEAD_TAIL   = HDR_BYTES - KEEP_W,
  localparam int CARRY_LANES = KEEP_W - HEAD_TAIL
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [DATA_W-1:0]       s_data,
  input  logic [KEEP_W-1:0]       s_keep,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic                    s_last,
  input  logic                    s_user,
  output logic                    hdr_valid,
  input  logic                    hdr_ready,
  output logic [8*MAC_BYTES-1:0]  hdr_dst,
  output logic [8*MAC_BYTES-1:0]  hdr_src,
  output logic [8*TYPE_BYTES-1:0] hdr_type,
  output logic [DATA_W-1:0]       p_data,
  output logic [KEEP_W-1:0]       p_keep,
  output logic                    p_valid,
  input  logic                    p_ready,
  output logic                    p_last,
  output logic                    p_user,
  output logic                    busy,
  output logic                    hdr_trunc_err
);
  logic hdr_free, pl_free, beat0_cap, hdr_cap, body_cap, tail_emit;
  logic o_last, o_user, in_frame;
  logic [KEEP_W-1:0] o_keep;

  fhs_ctrl #(.KEEP_W(KEEP_W), .HEAD_TAIL(HEAD_TAIL)) ctrl_i (
    .clk(clk), .rst(rst),
    .s_valid(s_valid), .s_last(s_last), .s_user(s_user), .s_keep(s_keep),
    .s_ready(s_ready), .hdr_free(hdr_free), .pl_free(pl_free),
    .beat0_cap(beat0_cap), .hdr_cap(hdr_cap), .body_cap(body_cap),
    .tail_emit(tail_emit), .o_keep(o_keep), .o_last(o_last), .o_user(o_user),
    .trunc_err(hdr_trunc_err), .in_frame(in_frame)
  );

  fhs_hdr_reg #(.DATA_W(DATA_W), .MAC_BYTES(MAC_BYTES), .TYPE_BYTES(TYPE_BYTES)) hdr_i (
    .clk(clk), .rst(rst), .s_data(s_data),
    .beat0_cap(beat0_cap), .hdr_cap(hdr_cap), .hdr_ready(hdr_ready),
    .hdr_valid(hdr_valid), .hdr_free(hdr_free),
    .hdr_dst(hdr_dst), .hdr_src(hdr_src), .hdr_type(hdr_type)
  );

  fhs_realign #(.DATA_W(DATA_W), .CARRY_LANES(CARRY_LANES)) realign_i (
    .clk(clk), .rst(rst), .s_data(s_data),
    .hdr_cap(hdr_cap), .body_cap(body_cap), .tail_emit(tail_emit),
    .o_keep(o_keep), .o_last(o_last), .o_user(o_user),
    .p_ready(p_ready), .p_valid(p_valid), .p_data(p_data), .p_keep(p_keep),
    .p_last(p_last), .p_user(p_user), .pl_free(pl_free)
  );

  assign busy = in_frame | p_valid;
endmodule

// File: rtl/frame_hdr_split_chk.sv
`timescale 1ns/1ps
module frame_hdr_split_chk #(
  parameter int DATA_W   = 64,
  parameter int KEEP_W   = 8,
  parameter int HDR_W    = 112
) (
  input logic              clk,
  input logic              rst,
  input logic              hdr_valid,
  input logic              hdr_ready,
  input logic [HDR_W-1:0]  hdr_all,
  input logic              p_valid,
  input logic              p_ready,
  input logic [DATA_W-1:0] p_data,
  input logic [KEEP_W-1:0] p_keep,
  input logic              p_last,
  input logic              p_user
);
  // R7
  pl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    p_valid && !p_ready |=> p_valid && $stable(p_data) && $stable(p_keep) &&
                            $stable(p_last) && $stable(p_user));

  // R8
  hdr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_all));

  // R2
  keep_contig_chk: assert property (@(posedge clk) disable iff (rst)
    p_valid |-> (p_keep != '0) && ((p_keep & (p_keep + KEEP_W'(1))) == '0));

  // R2
  mid_full_chk: assert property (@(posedge clk) disable iff (rst)
    p_valid && !p_last |-> (&p_keep));

  // R4
  user_end_chk: assert property (@(posedge clk) disable iff (rst)
    p_valid && p_user |-> p_last);
endmodule

bind frame_hdr_split frame_hdr_split_chk #(
  .DATA_W(DATA_W), .KEEP_W(KEEP_W), .HDR_W(8 * HDR_BYTES)
) chk_i (
  .clk(clk), .rst(rst),
  .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
  .hdr_all({hdr_dst, hdr_src, hdr_type}),
  .p_valid(p_valid), .p_ready(p_ready), .p_data(p_data), .p_keep(p_keep),
  .p_last(p_last), .p_user(p_user)
);

// File: tb/frame_hdr_split_tb_top.sv
`timescale 1ns/1ps
module frame_hdr_split_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic [63:0] s_data = '0;
  logic [7:0]  s_keep = '0;
  logic        s_valid = 1'b0, s_last = 1'b0, s_user = 1'b0;
  logic        s_ready;
  logic        hdr_valid, hdr_ready = 1'b1;
  logic [47:0] hdr_dst, hdr_src;
  logic [15:0] hdr_type;
  logic [63:0] p_data;
  logic [7:0]  p_keep;
  logic        p_valid, p_ready = 1'b1, p_last, p_user;
  logic        busy, hdr_trunc_err;

  frame_hdr_split dut_i (
    .clk(clk), .rst(rst), .s_data(s_data), .s_keep(s_keep), .s_valid(s_valid),
    .s_ready(s_ready), .s_last(s_last), .s_user(s_user),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_dst(hdr_dst),
    .hdr_src(hdr_src), .hdr_type(hdr_type), .p_data(p_data), .p_keep(p_keep),
    .p_valid(p_valid), .p_ready(p_ready), .p_last(p_last), .p_user(p_user),
    .busy(busy), .hdr_trunc_err(hdr_trunc_err)
  );

  int checks = 0, failures = 0;
  int mode = 0;
  int cyc = 0;

  byte unsigned  exp_b[$], rx_b[$];
  int            exp_len[$], rx_len[$], exp_nb[$], rx_nb[$];
  bit            exp_u[$], rx_u[$];
  logic [111:0]  exp_h[$], rx_h[$];
  int            rx_err = 0, exp_err = 0, rx_badmid = 0;
  int            cur_len = 0, cur_nb = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // output sinks and monitors
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      p_ready   = mode[1] ? (cyc % 3 != 1) : 1'b1;
      hdr_ready = mode[2] ? (cyc % 5 == 0) : 1'b1;
      #2;
      if (!rst) begin
        if (p_valid && p_ready) begin
          for (int k = 0; k < 8; k++)
            if (p_keep[k]) begin rx_b.push_back(p_data[8*k +: 8]); cur_len++; end
          cur_nb++;
          if (p_last) begin
            rx_len.push_back(cur_len); rx_nb.push_back(cur_nb); rx_u.push_back(p_user);
            cur_len = 0; cur_nb = 0;
          end else if (p_user || p_keep != 8'hFF) rx_badmid++;
        end
        if (hdr_valid && hdr_ready) rx_h.push_back({hdr_dst, hdr_src, hdr_type});
        if (hdr_trunc_err) rx_err++;
      end
    end
  end

  task automatic make_frame(input int f, input int total, output byte unsigned fb[$]);
    fb = {};
    for (int i = 0; i < total; i++) begin
      if (i < 6)       fb.push_back(8'(8'hD0 + i + f));
      else if (i < 12) fb.push_back(8'(8'h50 + i));
      else if (i == 12) fb.push_back(8'h88);
      else if (i == 13) fb.push_back(8'(f));
      else             fb.push_back(8'(f * 7 + i));
    end
  endtask

  task automatic expect_frame(input byte unsigned fb[$], input bit usr);
    logic [111:0] h = '0;
    int p = fb.size() - 14;
    if (p <= 0) return;
    for (int i = 0; i < 14; i++) h = {h[103:0], fb[i]};
    exp_h.push_back(h);
    for (int i = 14; i < fb.size(); i++) exp_b.push_back(fb[i]);
    exp_len.push_back(p);
    exp_nb.push_back((p + 7) / 8);
    exp_u.push_back(usr);
  endtask

  task automatic send_beats(input byte unsigned fb[$], input bit usr, input int first);
    int n = fb.size();
    int nbeats = (n + 7) / 8;
    for (int b = first; b < nbeats; b++) begin
      @(negedge clk);
      if (mode[0] && (b % 2 == 1)) begin s_valid = 1'b0; @(negedge clk); end
      s_data = '0; s_keep = '0;
      for (int k = 0; k < 8; k++)
        if (8 * b + k < n) begin s_data[8*k +: 8] = fb[8*b + k]; s_keep[k] = 1'b1; end
      s_last = (b == nbeats - 1);
      s_user = s_last && usr;
      s_valid = 1'b1;
      #2;
      while (!s_ready) begin @(negedge clk); #2; end
    end
  endtask

  task automatic src_idle();
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0; s_user = 1'b0;
  endtask

  task automatic drain();
    int quiet = 0;
    while (quiet < 8) begin
      @(negedge clk); #3;
      if (!busy && !p_valid && !hdr_valid) quiet++; else quiet = 0;
    end
  endtask

  task automatic compare(input string grp, input bit trunc_grp);
    bit ok; int idx;
    // R1 header contents and count
    ok = (rx_h.size() == exp_h.size()); idx = -1;
    for (int i = 0; i < exp_h.size() && ok; i++)
      if (rx_h[i] != exp_h[i]) begin ok = 0; idx = i; end
    chk(ok, "R1", {grp, " header"}, (idx >= 0) ? 128'(rx_h[idx]) : 128'(rx_h.size()),
        (idx >= 0) ? 128'(exp_h[idx]) : 128'(exp_h.size()));
    // R2 payload bytes in order, full middle beats
    ok = (rx_b.size() == exp_b.size()) && (rx_badmid == 0); idx = -1;
    for (int i = 0; i < exp_b.size() && ok; i++)
      if (rx_b[i] != exp_b[i]) begin ok = 0; idx = i; end
    chk(ok, "R2", {grp, " payload bytes"}, (idx >= 0) ? 128'(rx_b[idx]) : 128'(rx_b.size()),
        (idx >= 0) ? 128'(exp_b[idx]) : 128'(exp_b.size()));
    // R3 beat count and last-beat length
    ok = (rx_nb == exp_nb) && (rx_len == exp_len);
    chk(ok, "R3", {grp, " beats/len"}, 128'(rx_nb.size() ? rx_nb[0] : -1),
        128'(exp_nb.size() ? exp_nb[0] : -1));
    // R4 user passes to last beat
    chk(rx_u == exp_u, "R4", {grp, " user"}, 128'(rx_u.size() ? rx_u[0] : 0),
        128'(exp_u.size() ? exp_u[0] : 0));
    // R5 truncation pulse count
    chk(rx_err == exp_err, "R5", {grp, " trunc pulses"}, 128'(rx_err), 128'(exp_err));
    if (trunc_grp)
      chk(rx_len.size() == 1 && rx_h.size() == 1, "R6", {grp, " following frame"},
          128'(rx_len.size()), 128'(1));
    else
      chk(rx_len.size() == 2, "R7", {grp, " frames delivered"}, 128'(rx_len.size()), 128'(2));
    if (mode[2])
      chk(rx_h.size() == exp_h.size(), "R8", {grp, " headers under stall"},
          128'(rx_h.size()), 128'(exp_h.size()));
    exp_b = {}; rx_b = {}; exp_len = {}; rx_len = {}; exp_nb = {}; rx_nb = {};
    exp_u = {}; rx_u = {}; exp_h = {}; rx_h = {};
    rx_err = 0; exp_err = 0; rx_badmid = 0;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    byte unsigned fa[$], fb2[$];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    #2;
    // R10 reset state
    chk(s_ready == 1'b1, "R10", "s_ready after reset", 128'(s_ready), 128'(1));
    chk(!p_valid && !hdr_valid && !hdr_trunc_err, "R10", "valids after reset",
        128'({p_valid, hdr_valid, hdr_trunc_err}), 128'(0));
    chk(busy == 1'b0, "R9", "busy after reset", 128'(busy), 128'(0));

    // R9 busy mid-frame: first beat only, then pause
    mode = 0;
    make_frame(1, 30, fa);
    @(negedge clk);
    for (int k = 0; k < 8; k++) s_data[8*k +: 8] = fa[k];
    s_keep = 8'hFF; s_last = 1'b0; s_user = 1'b0; s_valid = 1'b1;
    #2; while (!s_ready) begin @(negedge clk); #2; end
    src_idle();
    repeat (3) @(negedge clk);
    #2;
    chk(busy == 1'b1, "R9", "busy inside frame", 128'(busy), 128'(1));
    chk(hdr_valid == 1'b0, "R1", "no header before byte 14", 128'(hdr_valid), 128'(0));
    send_beats(fa, 1'b1, 1);
    expect_frame(fa, 1'b1);
    src_idle();
    drain();
    chk(busy == 1'b0, "R9", "busy when idle", 128'(busy), 128'(0));
    // single frame: compare with a duplicate-count group tolerance
    exp_err = 0;
    begin
      bit ok = (rx_b == exp_b) && (rx_h == exp_h) && (rx_u == exp_u);
      chk(ok, "R2", "split frame payload", 128'(rx_b.size()), 128'(exp_b.size()));
    end
    exp_b = {}; rx_b = {}; exp_len = {}; rx_len = {}; exp_nb = {}; rx_nb = {};
    exp_u = {}; rx_u = {}; exp_h = {}; rx_h = {}; rx_err = 0; rx_badmid = 0;

    // back-to-back sweep: every stall mode, payload 1..17
    for (int m = 0; m < 8; m++) begin
      mode = m;
      for (int plen = 1; plen <= 17; plen++) begin
        make_frame(2 * plen, 14 + plen, fa);
        make_frame(2 * plen + 1, 14 + plen, fb2);
        expect_frame(fa, plen[0]);
        expect_frame(fb2, !plen[0]);
        send_beats(fa, plen[0], 0);
        send_beats(fb2, !plen[0], 0);
        src_idle();
        drain();
        compare($sformatf("mode%0d len%0d", m, plen), 1'b0);
      end
    end

    // truncated frame followed by a good one
    for (int tl = 1; tl <= 14; tl++) begin
      mode = tl % 8;
      make_frame(100 + tl, tl, fa);
      make_frame(120 + tl, 23, fb2);
      exp_err = 1;
      expect_frame(fb2, 1'b1);
      send_beats(fa, 1'b1, 0);
      send_beats(fb2, 1'b1, 0);
      src_idle();
      drain();
      compare($sformatf("trunc%0d", tl), 1'b1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule